// File: doc/BRIEF.md
# Wake-up interrupt polarity converter

A bank of per-pin interrupt conditioners placed in front of an interrupt controller that only accepts active-high levels and rising edges. Every pin is brought through a two-flop synchroniser and then conditioned according to its own 3-bit trigger type and enable bit. Active-low levels are inverted to active-high. Falling edges are reported the same way as rising edges. In dual-edge mode, every transition of the pin raises a request.

Any detected edge sets a per-pin pending latch, and that latch drives the output until software clears it. Software therefore can discard the spurious request that appears when a pin's polarity is rewritten while its input holds still. A small word-addressed register port gives access to the per-pin configuration words, a write-one-to-clear pending register and a fixed read-only version word. The port has a request, a write enable, byte strobes and a combinational read.

Top module: `wake_irq_conditioner`

## Requirements
- R1: After reset every configuration word reads 0, all pins are disabled, the pending register reads 0 and every `irq_o` bit is low.
- R2: Trigger type 3'b100 with enable set is active-high level: `irq_o[p]` equals the synchronised pin value.
- R3: Trigger type 3'b000 with enable set is active-low level: `irq_o[p]` equals the inverse of the synchronised pin value.
- R4: Trigger type 3'b110 with enable set is rising edge. A 0-to-1 pin transition sets pending bit p, and `irq_o[p]` then stays high until the bit is cleared. A 1-to-0 transition sets nothing.
- R5: Trigger type 3'b010 with enable set is falling edge. A 1-to-0 transition sets pending bit p and drives `irq_o[p]` high. A 0-to-1 transition sets nothing.
- R6: Trigger type 3'b111 with enable set is dual edge. A transition in either direction sets pending bit p and drives `irq_o[p]` high.
- R7: The pending register sits at byte address 0x010, with bit p for pin p. Reads return the pending latches. Writing 1 to a bit clears that latch. Rewriting an edge pin's polarity while its input holds still sets the latch, and a clear removes it.
- R8: The configuration word of pin p sits at byte address 0x110 + 4*p and holds 32 bits. The trigger type is in bits 2:0 and the enable is in bit 3. Byte lanes whose strobe in `be_i` is 0 keep their contents. A write reaches only the addressed pin's word.
- R9: Byte address 0x1000 reads 32'h0003_0200, and writes to it have no effect.
- R10: A pin whose enable bit is 0, or whose type is 001, 011 or 101, drives `irq_o` low and has its pending latch cleared. While the pin is in that state, its edge history follows the input, so enabling the pin while its input is steady raises no request.
- R11: In level modes a pin change sampled at one rising edge of `clk_i` appears on `irq_o` after the second rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous wake-up interrupt inputs |
| irq_o | output | NUM_PINS | Conditioned active-high requests to the interrupt controller |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| be_i | input | 4 | Byte strobes for writes |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |

## Verification
A vector table runs each trigger type on several pins under both a rising and a falling input transition. For each encoding this shows whether it passes or inverts a level, and which direction of edge it latches. Unused encodings and a disabled pin are put through the same transitions and must stay silent. Directed cases cover these points:
- the two-edge synchroniser delay;
- a phantom request caused by a polarity rewrite on a still input, and its removal through the pending register;
- enabling a pin that is already high without raising a stale edge;
- byte-lane isolation in the configuration words;
- the read-only version word.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int CFG_EN_BIT = 3;

  localparam logic [2:0] TRIG_LVL_LO    = 3'b000;
  localparam logic [2:0] TRIG_EDGE_FALL = 3'b010;
  localparam logic [2:0] TRIG_LVL_HI    = 3'b100;
  localparam logic [2:0] TRIG_EDGE_RISE = 3'b110;
  localparam logic [2:0] TRIG_EDGE_DUAL = 3'b111;

  function automatic logic trig_valid(input logic [2:0] t);
    case (t)
      TRIG_LVL_LO, TRIG_EDGE_FALL, TRIG_LVL_HI,
      TRIG_EDGE_RISE, TRIG_EDGE_DUAL: trig_valid = 1'b1;
      default:                        trig_valid = 1'b0;
    endcase
  endfunction

  // low-polarity encodings are flipped before detection
  function automatic logic trig_inverts(input logic [2:0] t);
    trig_inverts = (t == TRIG_LVL_LO) || (t == TRIG_EDGE_FALL);
  endfunction

  function automatic logic trig_is_level(input logic [2:0] t);
    trig_is_level = (t == TRIG_LVL_LO) || (t == TRIG_LVL_HI);
  endfunction
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wic_regs.sv
module wic_regs
  import wic_pkg::*;
#(
  parameter int          NUM_PINS  = 8,
  parameter int          ADDR_W    = 13,
  parameter logic [31:0] CFG_BASE  = 32'h110,
  parameter logic [31:0] PEND_ADDR = 32'h010,
  parameter logic [31:0] VER_ADDR  = 32'h1000,
  parameter logic [31:0] VER_VAL   = 32'h30200
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [3:0]                be_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_PINS-1:0]       pend_i,
  output logic [NUM_PINS-1:0][2:0]  cfg_type_o,
  output logic [NUM_PINS-1:0]       cfg_en_o,
  output logic [NUM_PINS-1:0]       clr_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] CFG_BASE_A = CFG_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CFG_SPAN_A = ADDR_W'(4 * NUM_PINS);
  localparam logic [ADDR_W-1:0] PEND_A     = PEND_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] VER_A      = VER_ADDR[ADDR_W-1:0];

  logic [31:0]       cfg_q [NUM_PINS];
  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;
  logic              wr;

  assign wr      = req_i && we_i;
  assign cfg_off = addr_i - CFG_BASE_A;
  assign cfg_hit = (addr_i >= CFG_BASE_A) && (cfg_off < CFG_SPAN_A) && (cfg_off[1:0] == 2'b00);
  assign cfg_idx = cfg_off[IDX_W+1:2];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[p] <= '0;
      end else if (wr && cfg_hit && (cfg_idx == IDX_W'(p))) begin
        for (int b = 0; b < 4; b++) begin
          if (be_i[b]) cfg_q[p][8*b +: 8] <= wdata_i[8*b +: 8];
        end
      end
    end
    assign cfg_type_o[p] = cfg_q[p][2:0];
    assign cfg_en_o[p]   = cfg_q[p][CFG_EN_BIT];
  end

  assign clr_o = (wr && (addr_i == PEND_A)) ? wdata_i[NUM_PINS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (cfg_hit)                rdata_o = cfg_q[cfg_idx];
    else if (addr_i == PEND_A)  rdata_o[NUM_PINS-1:0] = pend_i;
    else if (addr_i == VER_A)   rdata_o = VER_VAL;
  end
endmodule

// File: rtl/wic_pin_cond.sv
module wic_pin_cond
  import wic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [2:0] type_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       pend_o
);
  logic active, is_lvl, is_dual, cond, edge_p;
  logic prev_q, pend_q;

  assign active  = en_i && trig_valid(type_i);
  assign is_lvl  = trig_is_level(type_i);
  assign is_dual = (type_i == TRIG_EDGE_DUAL);
  assign cond    = pin_i ^ trig_inverts(type_i);
  assign edge_p  = active && !is_lvl && (is_dual ? (cond ^ prev_q) : (cond && !prev_q));

  // history always follows the conditioned level, so enabling never sees a stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= cond;
      if (!active || is_lvl) pend_q <= 1'b0;
      else if (edge_p)       pend_q <= 1'b1;
      else if (clr_i)        pend_q <= 1'b0;
    end
  end

  assign irq_o  = active && (is_lvl ? cond : pend_q);
  assign pend_o = pend_q;
endmodule

// File: rtl/wake_irq_conditioner.sv
module wake_irq_conditioner #(
  parameter int          NUM_PINS  = 8,
  parameter int          ADDR_W    = 13,
  parameter logic [31:0] CFG_BASE  = 32'h110,
  parameter logic [31:0] PEND_ADDR = 32'h010,
  parameter logic [31:0] VER_ADDR  = 32'h1000,
  parameter logic [31:0] VER_VAL   = 32'h30200
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] irq_o,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [3:0]          be_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o
);
  logic [NUM_PINS-1:0]      pin_sync;
  logic [NUM_PINS-1:0][2:0] cfg_type;
  logic [NUM_PINS-1:0]      cfg_en;
  logic [NUM_PINS-1:0]      clr;
  logic [NUM_PINS-1:0]      pend;

  wic_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  wic_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .CFG_BASE (CFG_BASE),
    .PEND_ADDR(PEND_ADDR),
    .VER_ADDR (VER_ADDR),
    .VER_VAL  (VER_VAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pend_i    (pend),
    .cfg_type_o(cfg_type),
    .cfg_en_o  (cfg_en),
    .clr_o     (clr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    wic_pin_cond u_cond (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_sync[p]),
      .type_i(cfg_type[p]),
      .en_i  (cfg_en[p]),
      .clr_i (clr[p]),
      .irq_o (irq_o[p]),
      .pend_o(pend[p])
    );
  end
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
  parameter int          NUM_PINS = 8,
  parameter int          ADDR_W   = 13,
  parameter logic [31:0] VER_ADDR = 32'h1000,
  parameter logic [31:0] VER_VAL  = 32'h30200
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_i,
  input logic                     we_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [31:0]              rdata_o,
  input logic [NUM_PINS-1:0]      irq_o,
  input logic [NUM_PINS-1:0][2:0] cfg_type_i,
  input logic [NUM_PINS-1:0]      cfg_en_i,
  input logic [NUM_PINS-1:0]      pend_i
);
  assert_version_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == VER_ADDR[ADDR_W-1:0]) |-> (rdata_o == VER_VAL));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    assert_disabled_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i[p] |-> !irq_o[p]);

    assert_unused_type_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_type_i[p] == 3'b001 || cfg_type_i[p] == 3'b011 || cfg_type_i[p] == 3'b101) |-> !irq_o[p]);

    assert_disabled_drops_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i[p] |=> !pend_i[p]);

    // R4/R5/R6: pending only rises out of an enabled edge mode
    assert_pend_from_edge_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[p]) |-> $past(cfg_en_i[p] &&
        (cfg_type_i[p] == 3'b010 || cfg_type_i[p] == 3'b110 || cfg_type_i[p] == 3'b111)));
  end
endmodule

bind wake_irq_conditioner wic_checker #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .VER_ADDR(VER_ADDR),
  .VER_VAL (VER_VAL)
) u_wic_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .cfg_type_i(cfg_type),
  .cfg_en_i  (cfg_en),
  .pend_i    (pend)
);

// File: tb/wake_irq_conditioner_bench.sv
`timescale 1ns/1ps
module wake_irq_conditioner_bench;
  localparam int N = 8;
  localparam logic [12:0] A_CFG  = 13'h110;
  localparam logic [12:0] A_PEND = 13'h010;
  localparam logic [12:0] A_VER  = 13'h1000;
  localparam int WATCHDOG_CYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '0;
  logic [N-1:0]  irq;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    be = 4'h0;
  logic [12:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wake_irq_conditioner u_wake_irq_conditioner (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .irq_o(irq),
    .req_i(req), .we_i(we), .be_i(be), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  // {pin[2:0], type[2:0], en, before, after, expected irq}
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {3'd0, 3'b100, 1'b1, 1'b0, 1'b1, 1'b1},  // R2
    {3'd1, 3'b100, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    {3'd2, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1},  // R3
    {3'd3, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0},  // R3
    {3'd4, 3'b110, 1'b1, 1'b0, 1'b1, 1'b1},  // R4
    {3'd5, 3'b110, 1'b1, 1'b1, 1'b0, 1'b0},  // R4
    {3'd6, 3'b010, 1'b1, 1'b1, 1'b0, 1'b1},  // R5
    {3'd7, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0},  // R5
    {3'd0, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1},  // R6
    {3'd1, 3'b111, 1'b1, 1'b1, 1'b0, 1'b1},  // R6
    {3'd2, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0},  // R10
    {3'd3, 3'b101, 1'b1, 1'b1, 1'b0, 1'b0},  // R10
    {3'd4, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0}   // R10
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] s);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = s;
    tick(1);
    req = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic reg_rd(input logic [12:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic logic [12:0] cfg_addr(input int p);
    return A_CFG + 13'(4 * p);
  endfunction

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
  end

  initial begin
    logic [31:0] rd;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    reg_rd(cfg_addr(0), rd); check("R1 cfg0", rd, 32'h0);
    reg_rd(cfg_addr(7), rd); check("R1 cfg7", rd, 32'h0);
    reg_rd(A_PEND, rd);      check("R1 pending", rd, 32'h0);

    // R9 version, read only
    reg_rd(A_VER, rd); check("R9 version", rd, 32'h30200);
    reg_wr(A_VER, 32'hFFFF_FFFF, 4'hF);
    reg_rd(A_VER, rd); check("R9 version after write", rd, 32'h30200);

    // vector table: R2..R6, R10
    for (int v = 0; v < NV; v++) begin
      int p;
      p = int'(VEC[v][9:7]);
      pin[p] = VEC[v][2];
      reg_wr(cfg_addr(p), {28'h0, VEC[v][3], VEC[v][6:4]}, 4'hF);
      tick(4);
      reg_wr(A_PEND, 32'(1) << p, 4'hF);
      tick(2);
      pin[p] = VEC[v][1];
      tick(4);
      check($sformatf("R2-6/R10 vec %0d irq", v), 32'(irq[p]), 32'(VEC[v][0]));
      reg_wr(cfg_addr(p), 32'h0, 4'hF);
      pin[p] = 1'b0;
      tick(3);
    end

    // R4 sticky until cleared
    pin[4] = 1'b0;
    reg_wr(cfg_addr(4), 32'hE, 4'hF);
    tick(4); reg_wr(A_PEND, 32'h10, 4'hF); tick(2);
    pin[4] = 1'b1; tick(4);
    pin[4] = 1'b0; tick(10);
    check("R4 held pending irq", 32'(irq[4]), 32'h1);
    reg_rd(A_PEND, rd); check("R4 pending bit", rd, 32'h10);
    reg_wr(A_PEND, 32'h10, 4'hF);
    check("R4 cleared", 32'(irq[4]), 32'h0);
    reg_wr(cfg_addr(4), 32'h0, 4'hF);

    // R8 byte lanes and per-pin isolation
    reg_wr(cfg_addr(2), 32'hDEAD_BEE0, 4'hF);
    reg_wr(cfg_addr(2), 32'h1111_1106, 4'h1);
    reg_rd(cfg_addr(2), rd); check("R8 byte0 only", rd, 32'hDEAD_BE06);
    reg_wr(cfg_addr(2), 32'h7700_0000, 4'h8);
    reg_rd(cfg_addr(2), rd); check("R8 byte3 only", rd, 32'h77AD_BE06);
    reg_rd(cfg_addr(3), rd); check("R8 neighbour untouched", rd, 32'h0);
    reg_wr(cfg_addr(2), 32'h0, 4'hF);

    // R11 two-edge synchroniser latency, level-high pin 5
    reg_wr(cfg_addr(5), 32'hC, 4'hF);
    tick(2);
    pin[5] = 1'b1;
    tick(1); check("R11 not after one edge", 32'(irq[5]), 32'h0);
    tick(1); check("R11 after two edges", 32'(irq[5]), 32'h1);
    reg_wr(cfg_addr(5), 32'h0, 4'hF);
    pin[5] = 1'b0;

    // R7 phantom from polarity rewrite on a still input
    pin[6] = 1'b0;
    reg_wr(cfg_addr(6), 32'hE, 4'hF);
    tick(4); reg_wr(A_PEND, 32'h40, 4'hF); tick(2);
    reg_rd(A_PEND, rd); check("R7 quiet before rewrite", rd, 32'h0);
    reg_wr(cfg_addr(6), 32'hA, 4'hF);
    tick(3);
    reg_rd(A_PEND, rd); check("R7 phantom pending", rd, 32'h40);
    reg_wr(A_PEND, 32'h40, 4'hF);
    reg_rd(A_PEND, rd); check("R7 pending cleared", rd, 32'h0);
    check("R7 irq after clear", 32'(irq[6]), 32'h0);
    reg_wr(cfg_addr(6), 32'h0, 4'hF);

    // R10 enabling a high pin raises nothing; disabling drops pending
    pin[7] = 1'b1;
    reg_wr(cfg_addr(7), 32'h6, 4'hF);
    tick(4); check("R10 disabled irq", 32'(irq[7]), 32'h0);
    reg_wr(cfg_addr(7), 32'hE, 4'hF);
    tick(4); check("R10 no stale edge", 32'(irq[7]), 32'h0);
    pin[7] = 1'b0; tick(4);
    pin[7] = 1'b1; tick(4);
    reg_rd(A_PEND, rd); check("R10 pending set", rd, 32'h80);
    reg_wr(cfg_addr(7), 32'h6, 4'hF);
    tick(1);
    reg_rd(A_PEND, rd); check("R10 pending dropped", rd, 32'h0);

    summary();
  end
endmodule